// File: doc/BRIEF.md
# Truth-Table Programmable Logic Unit

This block applies any one of the sixteen two-input Boolean functions bitwise to two operand vectors. The operation is not picked from a list of opcodes. The 4-bit function code is the truth table of the wanted function. Each result bit is produced by a small 4-to-1 selector. The two operand bits at that position steer the selector, and the selector chooses one of the four code bits. Because no decoding stage sits in front of the selectors, a new function needs no extra logic.

The unit is purely combinational. A surrounding datapath drives the two operands and the code, and reads the result vector and a zero indication in the same cycle. The operand width is a parameter with a default of 8.

Top module: `ttab_logic_unit`

## Requirements
- R1: For every bit i, the result bit is the code bit indexed by the 2-bit value {a_i[i], b_i[i]}. Index 0 (A=0,B=0) gives code bit 0. Index 1 (A=0,B=1) gives code bit 1. Index 2 (A=1,B=0) gives code bit 2. Index 3 (A=1,B=1) gives code bit 3.
- R2: One function code governs all bit positions at once. With code 4'b1100 the result equals a_i in every bit.
- R3: Code 4'b0000 yields an all-zero result for any operands.
- R4: Code 4'b1111 yields an all-one result for any operands.
- R5: The codes 4'b1000, 4'b1110, 4'b0111 and 4'b0001 give bitwise AND, OR, NAND and NOR respectively.
- R6: Code 4'b0110 gives bitwise XOR, and code 4'b1001 gives bitwise XNOR.
- R7: Code 4'b1100 passes A, 4'b0011 inverts A, 4'b1010 passes B, and 4'b0101 inverts B.
- R8: zero_o is 1 exactly when every bit of res_o is 0.
- R9: The unit holds no state. The outputs follow the present inputs without any clock, for all 16 codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand; high select bit of each selector |
| b_i | input | WIDTH | Second operand; low select bit of each selector |
| func_i | input | 4 | Truth table of the function to apply |
| res_o | output | WIDTH | Bitwise result |
| zero_o | output | 1 | High when res_o is all zeros |

## Verification
Both res_o and zero_o are due in the same cycle as the stimulus, with no register on the path. The bench therefore changes the inputs on the falling clock edge and samples two nanoseconds later, well before the next rising edge. Operands 8'b11001100 and 8'b10101010 place all four select combinations in every nibble, so the result must read back as the code repeated. A fixed-seed random sweep over all codes is compared against a sum-of-products reference, and the zero flag is checked on every vector.

// File: rtl/ttab_pkg.sv
package ttab_pkg;

  localparam int CODE_W = 4;

  typedef logic [CODE_W-1:0] ttab_code_t;

  localparam ttab_code_t TT_ZERO  = 4'b0000;
  localparam ttab_code_t TT_NOR   = 4'b0001;
  localparam ttab_code_t TT_NOTA  = 4'b0011;
  localparam ttab_code_t TT_NOTB  = 4'b0101;
  localparam ttab_code_t TT_XOR   = 4'b0110;
  localparam ttab_code_t TT_NAND  = 4'b0111;
  localparam ttab_code_t TT_AND   = 4'b1000;
  localparam ttab_code_t TT_XNOR  = 4'b1001;
  localparam ttab_code_t TT_PASSB = 4'b1010;
  localparam ttab_code_t TT_PASSA = 4'b1100;
  localparam ttab_code_t TT_OR    = 4'b1110;
  localparam ttab_code_t TT_ONE   = 4'b1111;

endpackage

// File: rtl/ttab_bit_sel.sv
module ttab_bit_sel
  import ttab_pkg::*;
(
  input  logic       a_bit,
  input  logic       b_bit,
  input  ttab_code_t code,
  output logic       y
);

  logic hi_pair;
  logic lo_pair;

  // a_bit is the high select, b_bit the low select
  always_comb begin
    hi_pair = b_bit ? code[3] : code[2];
    lo_pair = b_bit ? code[1] : code[0];
    y       = a_bit ? hi_pair : lo_pair;
  end

  always_comb begin
    a_r3_const_zero: assert (!(code == TT_ZERO) || (y == 1'b0))
      else $error("R3 violated: zero code gave one");
    a_r4_const_one: assert (!(code == TT_ONE) || (y == 1'b1))
      else $error("R4 violated: one code gave zero");
    a_r1_both_high: assert (!(a_bit && b_bit) || (y == code[3]))
      else $error("R1 violated: select 11 did not pass code bit 3");
  end

endmodule

// File: rtl/ttab_zero_tree.sv
module ttab_zero_tree #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] vec,
  output logic             all_zero
);

  localparam int LVLS   = (WIDTH > 1) ? $clog2(WIDTH) : 0;
  localparam int LEAVES = 1 << LVLS;
  localparam int NODES  = 2 * LEAVES - 1;

  logic [NODES-1:0] node;

  for (genvar l = 0; l < LEAVES; l++) begin : g_leaf
    if (l < WIDTH) begin : g_real
      assign node[LEAVES-1+l] = vec[l];
    end else begin : g_pad
      assign node[LEAVES-1+l] = 1'b0;
    end
  end

  for (genvar k = 0; k < LEAVES-1; k++) begin : g_inner
    assign node[k] = node[2*k+1] | node[2*k+2];
  end

  assign all_zero = ~node[0];

endmodule

// File: rtl/ttab_logic_unit.sv
module ttab_logic_unit
  import ttab_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       func_i,
  output logic [WIDTH-1:0] res_o,
  output logic             zero_o
);

  ttab_code_t code;
  assign code = ttab_code_t'(func_i);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    ttab_bit_sel u_sel (
      .a_bit (a_i[i]),
      .b_bit (b_i[i]),
      .code  (code),
      .y     (res_o[i])
    );
  end

  ttab_zero_tree #(.WIDTH(WIDTH)) u_zero (
    .vec      (res_o),
    .all_zero (zero_o)
  );

  always_comb begin
    a_r8_zero_flag: assert (zero_o == ($countones(res_o) == 0))
      else $error("R8 violated: zero flag disagrees with result");
    a_r2_pass_a: assert (!(code == TT_PASSA) || (res_o == a_i))
      else $error("R2 violated: pass-A code did not reproduce A");
    a_r5_and: assert (!(code == TT_AND) || (res_o == (a_i & b_i)))
      else $error("R5 violated: AND code mismatch");
    a_r6_xor: assert (!(code == TT_XOR) || (res_o == (a_i ^ b_i)))
      else $error("R6 violated: XOR code mismatch");
    a_r7_not_b: assert (!(code == TT_NOTB) || (res_o == ~b_i))
      else $error("R7 violated: NOT-B code mismatch");
  end

endmodule

// File: tb/ttab_logic_unit_test.sv
module ttab_logic_unit_test;

  localparam int W = 8;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a_i;
  logic [W-1:0] b_i;
  logic [3:0]   func_i;
  logic [W-1:0] res_o;
  logic         zero_o;

  int  checks;
  int  errors;
  int  cycles;
  bit  done;

  ttab_logic_unit #(.WIDTH(W)) uut (
    .a_i    (a_i),
    .b_i    (b_i),
    .func_i (func_i),
    .res_o  (res_o),
    .zero_o (zero_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [W-1:0] ref_res(logic [W-1:0] a, logic [W-1:0] b,
                                           logic [3:0] g);
    ref_res = ({W{g[0]}} & ~a & ~b) | ({W{g[1]}} & ~a & b) |
              ({W{g[2]}} & a & ~b)  | ({W{g[3]}} & a & b);
  endfunction

  task automatic check_vec(string req, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic check_bit(string req, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic apply(logic [W-1:0] a, logic [W-1:0] b, logic [3:0] g);
    @(negedge clk);
    a_i = a;
    b_i = b;
    func_i = g;
    #2;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!done && cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  initial begin
    logic [W-1:0] ra;
    logic [W-1:0] rb;
    logic [3:0]   rg;
    logic [W-1:0] e;
    void'($urandom(32'd1234));
    checks = 0; errors = 0; cycles = 0; done = 1'b0;
    rst_n = 1'b0;
    a_i = '0; b_i = '0; func_i = 4'b0000;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Reset state: zero operands, zero code
    apply('0, '0, 4'b0000);
    check_vec("R3 reset result", res_o, '0);
    check_bit("R8 reset zero flag", zero_o, 1'b1);

    // R1: operands expose all four select values in each nibble
    for (int g = 0; g < 16; g++) begin
      apply(8'b1100_1100, 8'b1010_1010, 4'(g));
      check_vec("R1 truth-table readback", res_o, {2{4'(g)}});
    end

    // R2/R7: pass and invert of each operand
    apply(8'h5A, 8'h3C, 4'b1100);
    check_vec("R2 pass A across all bits", res_o, 8'h5A);
    check_vec("R7 pass A", res_o, 8'h5A);
    apply(8'h5A, 8'h3C, 4'b0011);
    check_vec("R7 not A", res_o, 8'hA5);
    apply(8'h5A, 8'h3C, 4'b1010);
    check_vec("R7 pass B", res_o, 8'h3C);
    apply(8'h5A, 8'h3C, 4'b0101);
    check_vec("R7 not B", res_o, 8'hC3);

    // R3/R4 constants
    apply(8'hFF, 8'hFF, 4'b0000);
    check_vec("R3 zero with ones in", res_o, 8'h00);
    check_bit("R8 flag on zero code", zero_o, 1'b1);
    apply(8'h00, 8'h00, 4'b1111);
    check_vec("R4 one with zeros in", res_o, 8'hFF);
    check_bit("R8 flag low on ones", zero_o, 1'b0);

    // R5/R6 named functions
    apply(8'hF0, 8'hCC, 4'b1000);
    check_vec("R5 AND", res_o, 8'hC0);
    apply(8'hF0, 8'hCC, 4'b1110);
    check_vec("R5 OR", res_o, 8'hFC);
    apply(8'hF0, 8'hCC, 4'b0111);
    check_vec("R5 NAND", res_o, 8'h3F);
    apply(8'hF0, 8'hCC, 4'b0001);
    check_vec("R5 NOR", res_o, 8'h03);
    apply(8'hF0, 8'hCC, 4'b0110);
    check_vec("R6 XOR", res_o, 8'h3C);
    apply(8'hF0, 8'hCC, 4'b1001);
    check_vec("R6 XNOR", res_o, 8'hC3);

    // R8: AND of disjoint operands, single set bit
    apply(8'hAA, 8'h55, 4'b1000);
    check_bit("R8 flag on disjoint AND", zero_o, 1'b1);
    apply(8'h80, 8'h00, 4'b1100);
    check_bit("R8 flag with only MSB set", zero_o, 1'b0);
    apply(8'h00, 8'h01, 4'b1010);
    check_bit("R8 flag with only LSB set", zero_o, 1'b0);

    // R9: random sweep, no state carried between vectors
    for (int n = 0; n < 400; n++) begin
      ra = W'($urandom);
      rb = W'($urandom);
      rg = 4'($urandom);
      apply(ra, rb, rg);
      e = ref_res(ra, rb, rg);
      check_vec("R9 random vector", res_o, e);
      check_bit("R8 random zero flag", zero_o, (e == '0));
    end

    done = 1'b1;
    finish_run();
  end

endmodule